// File: doc/BRIEF.md
# Configurable Input Capture Cell

This cell sits on the receive side of a general-purpose pad. The pad value is always available on two bypass outputs, so it can go straight into the fabric. The same value also feeds one storage element. Static configuration inputs choose how that element behaves: it is either an edge-triggered flip-flop or a level-sensitive latch, its clock can be used as is or inverted, and it has a chosen initial value that it takes on power-up or when the global initialise line is raised.

The cell has a clock enable. A parameter states whether the enable pin is wired at all. When it is not wired, the element behaves as if the enable were always high. A wide input bus is built by setting the data width parameter, and every lane shares the same clock, enable and configuration.

Top module: `pad_capture_cell`

## Requirements
- R1: `byp_a_o` and `byp_b_o` equal `pad_i` at all times, whatever the mode, enable, clock or initialise state.
- R2: With `cfg_latch_i` = 0 (edge mode), `q_reg_o` takes `pad_i` on each rising edge of the effective clock while the enable is high. It does not change between those edges.
- R3: With `cfg_latch_i` = 1 (level mode), `q_reg_o` follows `pad_i` while the effective clock is low and the enable is high. It holds its value while the effective clock is high.
- R4: While the enable is low, `q_reg_o` keeps its value in both modes, whatever the clock and pad do.
- R5: While `glob_init_i` is high, `q_reg_o` equals `cfg_init_val_i` at once, without waiting for a clock edge. This takes priority over clock, enable and pad.
- R6: While `rst_ni` is low (power-up), `q_reg_o` equals `cfg_init_val_i` at once, without waiting for a clock edge.
- R7: With parameter `CE_CONNECTED` = 0 (the default), `ce_i` is ignored and the element behaves as if always enabled.
- R8: With `cfg_clk_inv_i` = 1, the effective clock is the inverse of `clk_i`. Edge mode then captures on the falling edge of `clk_i`, and level mode is transparent while `clk_i` is high.
- R9: After `glob_init_i` or `rst_ni` is released, `q_reg_o` keeps the initial value until the first enabled capture edge or transparent phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, before polarity selection |
| rst_ni | input | 1 | Active-low power-up reset; loads the initial value |
| pad_i | input | WIDTH | Value received from the pad |
| ce_i | input | 1 | Clock enable; ignored when CE_CONNECTED = 0 |
| glob_init_i | input | 1 | Global initialise; forces the initial value while high |
| cfg_latch_i | input | 1 | 0 = edge-triggered, 1 = level-sensitive |
| cfg_clk_inv_i | input | 1 | 1 = invert clock before the storage element |
| cfg_init_val_i | input | WIDTH | Value loaded on reset or global initialise |
| byp_a_o | output | WIDTH | Unregistered pad value, first route |
| byp_b_o | output | WIDTH | Unregistered pad value, second route |
| q_reg_o | output | WIDTH | Storage element output |

## Verification
The bypass outputs and the forced initial value take effect in the same time step as their cause. The bench checks them 1 ns after the stimulus, in the middle of a clock phase. An edge-mode capture is due on the next effective rising edge, and a level-mode change is due as soon as the transparent phase is open. Each table vector drives its inputs just after a falling edge of `clk_i`, then checks 1 ns after the following falling edge. That window contains one edge and one phase of each polarity, so every mode and polarity has settled by the check. Directed tests sample inside a single phase to show that the element holds in its closed phase and does not capture on the wrong edge.

// File: rtl/pad_cell_pkg.sv
package pad_cell_pkg;
  typedef enum logic {
    STORE_EDGE  = 1'b0,
    STORE_LEVEL = 1'b1
  } store_kind_e;
endpackage

// File: rtl/pad_cell_clkpol.sv
module pad_cell_clkpol (
  input  logic clk_i,
  input  logic inv_i,
  output logic clk_o
);
  assign clk_o = clk_i ^ inv_i;
endmodule

// File: rtl/pad_cell_edge.sv
module pad_cell_edge #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [WIDTH-1:0] init_val_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge init_i) begin
    if (!rst_ni || init_i) q_o <= init_val_i;
    else if (en_i)         q_o <= d_i;
  end

  // R2: enabled edge loads data seen at that edge
  a_r2_edge_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || init_i)
    en_i |=> (q_o == $past(d_i)))
    else $error("a_r2_edge_capture");
endmodule

// File: rtl/pad_cell_level.sv
module pad_cell_level #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [WIDTH-1:0] init_val_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic open_w;
  assign open_w = en_i & ~clk_i;

  always_latch begin
    if (!rst_ni || init_i) q_o <= init_val_i;
    else if (open_w)       q_o <= d_i;
  end

  // R3: just before closing, output still tracks data
  a_r3_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni || init_i)
    en_i |-> (q_o == d_i))
    else $error("a_r3_level_follow");
endmodule

// File: rtl/pad_capture_cell.sv
module pad_capture_cell
  import pad_cell_pkg::*;
#(
  parameter int unsigned WIDTH        = 1,
  parameter bit          CE_CONNECTED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pad_i,
  input  logic             ce_i,
  input  logic             glob_init_i,
  input  logic             cfg_latch_i,
  input  logic             cfg_clk_inv_i,
  input  logic [WIDTH-1:0] cfg_init_val_i,
  output logic [WIDTH-1:0] byp_a_o,
  output logic [WIDTH-1:0] byp_b_o,
  output logic [WIDTH-1:0] q_reg_o
);
  logic             clk_eff;
  logic             ce_eff;
  logic [WIDTH-1:0] q_edge;
  logic [WIDTH-1:0] q_level;
  store_kind_e      kind;

  assign kind    = store_kind_e'(cfg_latch_i);
  assign byp_a_o = pad_i;
  assign byp_b_o = pad_i;

  // unwired enable reads as active
  generate
    if (CE_CONNECTED) begin : g_ce_pin
      assign ce_eff = ce_i;
    end else begin : g_ce_tied
      logic unused_ce;
      assign unused_ce = ce_i;
      assign ce_eff    = 1'b1;
    end
  endgenerate

  pad_cell_clkpol u_clkpol (
    .clk_i (clk_i),
    .inv_i (cfg_clk_inv_i),
    .clk_o (clk_eff)
  );

  pad_cell_edge #(.WIDTH(WIDTH)) u_edge (
    .clk_i      (clk_eff),
    .rst_ni     (rst_ni),
    .init_i     (glob_init_i),
    .init_val_i (cfg_init_val_i),
    .en_i       (ce_eff),
    .d_i        (pad_i),
    .q_o        (q_edge)
  );

  pad_cell_level #(.WIDTH(WIDTH)) u_level (
    .clk_i      (clk_eff),
    .rst_ni     (rst_ni),
    .init_i     (glob_init_i),
    .init_val_i (cfg_init_val_i),
    .en_i       (ce_eff),
    .d_i        (pad_i),
    .q_o        (q_level)
  );

  assign q_reg_o = (kind == STORE_LEVEL) ? q_level : q_edge;

  // R4: enable low over a whole clock period leaves output alone
  a_r4_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni || glob_init_i)
    (!ce_eff && $past(!ce_eff)) |-> $stable(q_reg_o))
    else $error("a_r4_hold_disabled");

  // R5: global initialise overrides everything
  a_r5_glob_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_init_i |-> (q_reg_o == cfg_init_val_i))
    else $error("a_r5_glob_force");

  // R6: power-up reset value, sampled mid-period
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r6_reset_force: assert (q_reg_o == cfg_init_val_i)
        else $error("a_r6_reset_force");
    end
  end
endmodule

// File: tb/pad_capture_cell_tb_top.sv
module pad_capture_cell_tb_top;
  localparam int W = 1;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] pad;
  logic         ce;
  logic         glob;
  logic         cfg_latch;
  logic         cfg_inv;
  logic [W-1:0] init_val;
  logic [W-1:0] byp_a, byp_b, q;
  logic [W-1:0] d_byp_a, d_byp_b, d_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pad_capture_cell #(.WIDTH(W), .CE_CONNECTED(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .ce_i(ce), .glob_init_i(glob),
    .cfg_latch_i(cfg_latch), .cfg_clk_inv_i(cfg_inv), .cfg_init_val_i(init_val),
    .byp_a_o(byp_a), .byp_b_o(byp_b), .q_reg_o(q)
  );

  // default build: enable pin not wired, driven low here to show it is ignored
  pad_capture_cell #(.WIDTH(W)) dflt_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .ce_i(1'b0), .glob_init_i(glob),
    .cfg_latch_i(cfg_latch), .cfg_clk_inv_i(cfg_inv), .cfg_init_val_i(init_val),
    .byp_a_o(d_byp_a), .byp_b_o(d_byp_b), .q_reg_o(d_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {latch, inv, ce, pad, expected q}
  localparam logic [4:0] VEC [0:14] = '{
    5'b00111, 5'b00100, 5'b00010, 5'b00111, 5'b00001,
    5'b01111, 5'b01100, 5'b01010,
    5'b10010, 5'b10111, 5'b10001, 5'b10100,
    5'b11111, 5'b11001, 5'b11100
  };

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic reconfig(input logic lat, input logic inv, input logic [W-1:0] iv);
    @(negedge clk); #1;
    glob = 1'b1; ce = 1'b0; pad = '0;
    cfg_latch = lat; cfg_inv = inv; init_val = iv;
    @(posedge clk); @(negedge clk); #1;
    glob = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic cur_lat, cur_inv;
    rst_n = 1'b0; glob = 1'b0; ce = 1'b0; pad = '0;
    cfg_latch = 1'b0; cfg_inv = 1'b0; init_val = '1;

    // R6: power-up value
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R6 reset value", q, '1);
    chk("R6 reset value default build", d_q, '1);
    rst_n = 1'b1;
    // R9: holds initial value while disabled
    @(posedge clk); @(negedge clk); #1;
    chk("R9 hold after reset release", q, '1);

    cur_lat = 1'b0; cur_inv = 1'b0;
    for (int i = 0; i < 15; i++) begin
      string tag;
      logic [4:0] v;
      v = VEC[i];
      if (i == 0 || v[4] != cur_lat || v[3] != cur_inv) begin
        reconfig(v[4], v[3], '0);
        cur_lat = v[4]; cur_inv = v[3];
      end
      @(negedge clk); #1;
      ce = v[2]; pad = W'(v[1]);
      #1;
      chk("R1 bypass a", byp_a, W'(v[1]));
      chk("R1 bypass b", byp_b, W'(v[1]));
      @(posedge clk); @(negedge clk); #1;
      if (!v[2])     tag = "R4 hold when disabled";
      else if (v[3]) tag = "R8 inverted clock";
      else if (v[4]) tag = "R3 level mode";
      else           tag = "R2 edge mode";
      chk(tag, q, W'(v[0]));
      chk("R7 enable ignored by default", d_q, W'(v[1]));
    end

    // R5 / R9: forced value beats open latch, then first open phase takes over
    reconfig(1'b1, 1'b0, '1);
    chk("R9 init held after release", q, '1);
    @(negedge clk); #1;
    ce = 1'b1; pad = '1;
    #1;
    glob = 1'b1; pad = '0;
    #1;
    chk("R5 forced during transparent phase", q, '1);
    chk("R1 bypass during init", byp_a, '0);
    @(posedge clk); @(negedge clk); #1;
    glob = 1'b0;
    #1;
    chk("R9 first transparent phase after release", q, '0);

    // R3: closed while clock high, opens at falling edge
    @(posedge clk); #1;
    pad = '1;
    #1;
    chk("R3 hold in high phase", q, '0);
    @(negedge clk); #1;
    chk("R3 transparent in low phase", q, '1);

    // R8: inverted edge mode ignores rising edge, captures on falling
    reconfig(1'b0, 1'b1, '0);
    @(posedge clk); #1;
    ce = 1'b1; pad = '1;
    #1;
    chk("R8 no capture on rising edge", q, '0);
    @(negedge clk); #1;
    chk("R8 capture on falling edge", q, '1);

    // R2: normal edge mode is not transparent in either phase
    reconfig(1'b0, 1'b0, '0);
    @(negedge clk); #1;
    ce = 1'b1; pad = '1;
    #1;
    chk("R2 no change in low phase", q, '0);
    @(posedge clk); #1;
    chk("R2 capture on rising edge", q, '1);
    pad = '0;
    #1;
    chk("R2 no change in high phase", q, '1);
    ce = 1'b0;

    // R6: reset mid-run acts without a clock edge
    @(posedge clk); #1;
    chk("R4 edge mode disabled hold", q, '1);
    rst_n = 1'b0;
    #1;
    chk("R6 asynchronous reset", q, '0);
    @(negedge clk); @(posedge clk); #1;
    rst_n = 1'b1;

    // R4: level mode with enable low stays shut in its open phase
    reconfig(1'b1, 1'b0, '0);
    @(negedge clk); #1;
    ce = 1'b0; pad = '1;
    #1;
    chk("R4 level mode disabled in low phase", q, '0);
    @(posedge clk); #1;
    pad = '0;
    @(negedge clk); #1;
    pad = '1;
    #1;
    chk("R4 level mode disabled next cycle", q, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule